// File: doc/BRIEF.md
# Tuner Control Register Slave

This block is a two-wire serial slave that holds the programming state of a frequency synthesizer. A bus master writes a 15-bit divider word, a 7-bit control field and a 5-bit port field into it, and can read back one status byte. The status byte carries a sticky power-up flag, the synthesizer lock indication and three comparator levels. SCL and SDA are oversampled by the system clock. The slave drives SDA only by pulling it low: `sda_oe` high means the pad is pulled to ground.

After an address byte for this slave, the write data is handled as groups. The most significant bit of the first byte of a group picks the group type. A divider group has two bytes, and the divider register changes only when both bytes have arrived. A control group has a control byte followed by a port byte, and each of these updates its own register as soon as it completes. Any number of groups may follow one address, up to STOP. A STOP or a repeated START discards a group that is half received and keeps every register that is already updated.

Top module: `tuner_i2c_regs`

## Requirements
- R1: The slave responds to the 7-bit address {1,1,0,0,0,addr_sel[1],addr_sel[0]}. The eighth bit of the address byte selects write (0) or read (1). A matching address byte is acknowledged by pulling SDA low in the ninth clock. Any other address gets no acknowledge, and its following bytes change no register.
- R2: In a write transfer, every data byte is acknowledged with SDA low in its ninth clock.
- R3: In a group, a first byte with MSB 0 starts a divider pair. Its bits 6..0 become div_word[14:8], and the next byte becomes div_word[7:0]. div_word does not change until that second byte completes.
- R4: In a group, a first byte with MSB 1 is a control byte. Its bits 6..0 load ctrl_reg[6:0] (charge-pump current, test, pump disable, two test selects, reference divide select, tuning-output disable). The byte after it is a port byte: bits 7,6,5,4 and 0 load port_reg[4:0], and bits 3..1 are ignored.
- R5: Several groups may follow one address byte within a single transfer, and each one updates its register as it completes.
- R6: A STOP in the middle of a group leaves all registers as they are and discards the partial group. The first byte after the next address starts a new group.
- R7: A read returns the status byte MSB first as {por_flag, lock_i, cmp_i[2], cmp_i[1], cmp_i[0], 1, 1, 1}. Further bytes are returned while the master acknowledges.
- R8: por_flag is 1 after reset and clears only once a status byte holding it has been sent, so any later byte reads it as 0.
- R9: After reset: div_word = 0, ctrl_reg = 7'b0000011 (reference divide-by-64 selected, tuning output off), port_reg = 0, and SDA is released.
- R10: After the master does not acknowledge a read byte, the slave releases SDA. It then stays silent through further SCL pulses until the next START.
- R11: A repeated START restarts address reception and discards any partial group.
- R12: The slave changes sda_oe only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high power-up reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data level seen on the bus |
| sda_oe | output | 1 | When high, the SDA pad is pulled low |
| addr_sel | input | 2 | Hardware address select bits |
| lock_i | input | 1 | Synthesizer lock indication |
| cmp_i | input | 3 | Comparator levels reported in the status byte |
| div_word | output | 15 | Divider ratio register |
| ctrl_reg | output | 7 | Control field register |
| port_reg | output | 5 | Port field register {P7,P6,P5,P4,P0} |

## Verification
Divider writes are checked between the two bytes of a pair as well as after the pair, so an early update is caught. One long transfer chains divider, control and divider groups to show that the group phase wraps correctly. An abort test ends a transfer after half a divider pair and then sends a control byte, and a repeated-START test does the same with another divider pair. A slave that kept the partial byte would mistake those bytes for the divider's low half. Reads run with two different input patterns and with both acknowledge and no acknowledge from the master, which separates the sticky power-up flag from the live inputs. Foreign addresses confirm that the slave stays silent.

// File: rtl/tuner_i2c_pkg.sv
package tuner_i2c_pkg;
  localparam logic [4:0] DEV_ID       = 5'b11000;
  localparam int         DIV_W        = 15;
  localparam int         CTRL_W       = 7;
  localparam int         PORT_W       = 5;
  localparam int         AUX_W        = 4;
  localparam logic [CTRL_W-1:0] CTRL_DEFAULT = 7'b0000011;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WRITE, ST_WACK, ST_READ, ST_RACK
  } slv_state_t;

  typedef enum logic [1:0] {
    GP_HEAD, GP_DIV_LO, GP_PORT
  } grp_phase_t;
endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int AUX_W       = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [AUX_W-1:0] aux_i,
  output logic             scl_s,
  output logic             sda_s,
  output logic             scl_rise,
  output logic             scl_fall,
  output logic             bus_start,
  output logic             bus_stop,
  output logic [AUX_W-1:0] aux_s
);
  logic [SYNC_STAGES-1:0] scl_chain, sda_chain;
  logic [AUX_W-1:0]       aux_chain [SYNC_STAGES];
  logic                   scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_chain <= '1;
      sda_chain <= '1;
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
    end else begin
      scl_chain <= {scl_chain[SYNC_STAGES-2:0], scl_i};
      sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_i};
      scl_q     <= scl_chain[SYNC_STAGES-1];
      sda_q     <= sda_chain[SYNC_STAGES-1];
    end
  end

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_aux
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) aux_chain[g] <= '0;
        else     aux_chain[g] <= aux_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) aux_chain[g] <= '0;
        else     aux_chain[g] <= aux_chain[g-1];
      end
    end
  end

  assign scl_s     = scl_chain[SYNC_STAGES-1];
  assign sda_s     = sda_chain[SYNC_STAGES-1];
  assign aux_s     = aux_chain[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // conditions: data edge while clock held high on both samples
  assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
  assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_slave_core.sv
module i2c_slave_core
  import tuner_i2c_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       bus_start,
  input  logic       bus_stop,
  input  logic [1:0] addr_sel,
  input  logic [7:0] status_byte,
  output logic       sda_oe,
  output logic       wr_stb,
  output logic [7:0] wr_data,
  output logic       rd_done
);
  slv_state_t state;
  logic [3:0] cnt;
  logic [7:0] shreg;
  logic       rw;
  logic       nack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      rw      <= 1'b0;
      nack    <= 1'b1;
      sda_oe  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_data <= '0;
      rd_done <= 1'b0;
    end else begin
      wr_stb  <= 1'b0;
      rd_done <= 1'b0;
      if (bus_start) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (bus_stop) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WRITE: begin
            if (scl_rise && cnt < 4'd8) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (state == ST_ADDR) begin
                if (shreg[7:1] == {DEV_ID, addr_sel}) begin
                  sda_oe <= 1'b1;
                  rw     <= shreg[0];
                  state  <= ST_AACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                sda_oe  <= 1'b1;
                wr_stb  <= 1'b1;
                wr_data <= shreg;
                state   <= ST_WACK;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                shreg  <= status_byte;
                sda_oe <= ~status_byte[7];
                state  <= ST_READ;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_WRITE;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              state  <= ST_WRITE;
            end
          end
          ST_READ: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                sda_oe  <= 1'b0;
                rd_done <= 1'b1;
                state   <= ST_RACK;
              end else begin
                shreg  <= {shreg[6:0], 1'b0};
                sda_oe <= ~shreg[6];
                cnt    <= cnt + 4'd1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              nack <= sda_s;
            end else if (scl_fall) begin
              if (nack) begin
                state <= ST_IDLE;
              end else begin
                shreg  <= status_byte;
                sda_oe <= ~status_byte[7];
                cnt    <= '0;
                state  <= ST_READ;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R1: an idle slave never pulls the line
  a_r1_idle_silent: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe);
  // R10: line released during the master's acknowledge slot
  a_r10_rack_released: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RACK) |-> !sda_oe);
  // R6: a stop always leaves the line released
  a_r6_stop_release: assert property (@(posedge clk) disable iff (rst)
    $past(bus_stop) |-> !sda_oe);
endmodule

// File: rtl/tuner_reg_file.sv
module tuner_reg_file
  import tuner_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              grp_clear,
  input  logic              wr_stb,
  input  logic [7:0]        wr_data,
  input  logic              rd_done,
  output logic [DIV_W-1:0]  div_word,
  output logic [CTRL_W-1:0] ctrl_reg,
  output logic [PORT_W-1:0] port_reg,
  output logic              por_flag
);
  grp_phase_t phase;
  logic [6:0] div_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= GP_HEAD;
      div_hi   <= '0;
      div_word <= '0;
      ctrl_reg <= CTRL_DEFAULT;
      port_reg <= '0;
      por_flag <= 1'b1;
    end else begin
      if (rd_done) por_flag <= 1'b0;
      if (grp_clear) begin
        phase <= GP_HEAD;
      end else if (wr_stb) begin
        case (phase)
          GP_HEAD: begin
            if (wr_data[7]) begin
              ctrl_reg <= wr_data[6:0];
              phase    <= GP_PORT;
            end else begin
              div_hi <= wr_data[6:0];
              phase  <= GP_DIV_LO;
            end
          end
          GP_DIV_LO: begin
            div_word <= {div_hi, wr_data};
            phase    <= GP_HEAD;
          end
          GP_PORT: begin
            port_reg <= {wr_data[7:4], wr_data[0]};
            phase    <= GP_HEAD;
          end
          default: phase <= GP_HEAD;
        endcase
      end
    end
  end

  // R3: divider only moves right after a completed write byte
  a_r3_div_needs_write: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_stb) |-> $stable(div_word));
  // R4: control field only moves right after a completed write byte
  a_r4_ctrl_needs_write: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_stb) |-> $stable(ctrl_reg));
  // R8: once cleared the power-up flag stays clear
  a_r8_por_stays_low: assert property (@(posedge clk) disable iff (rst)
    !por_flag |=> !por_flag);
  // R8: clearing is caused only by a sent status byte
  a_r8_por_clear_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(por_flag) |-> $past(rd_done));
endmodule

// File: rtl/tuner_i2c_regs.sv
module tuner_i2c_regs
  import tuner_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        addr_sel,
  input  logic              lock_i,
  input  logic [2:0]        cmp_i,
  output logic [DIV_W-1:0]  div_word,
  output logic [CTRL_W-1:0] ctrl_reg,
  output logic [PORT_W-1:0] port_reg
);
  logic             scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic [AUX_W-1:0] aux_s;
  logic             wr_stb, rd_done, por_flag;
  logic [7:0]       wr_data, status_byte;

  i2c_line_cond #(.SYNC_STAGES(SYNC_STAGES), .AUX_W(AUX_W)) u_cond (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .aux_i({lock_i, cmp_i}),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop), .aux_s(aux_s)
  );

  assign status_byte = {por_flag, aux_s, 3'b111};

  i2c_slave_core u_core (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop),
    .addr_sel(addr_sel), .status_byte(status_byte), .sda_oe(sda_oe),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_done(rd_done)
  );

  tuner_reg_file u_regs (
    .clk(clk), .rst(rst), .grp_clear(bus_start | bus_stop),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_done(rd_done),
    .div_word(div_word), .ctrl_reg(ctrl_reg), .port_reg(port_reg),
    .por_flag(por_flag)
  );

  // R12: the pull-down never toggles while the sampled clock is high
  a_r12_quiet_scl_high: assert property (@(posedge clk) disable iff (rst)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));
endmodule

// File: tb/sim_tuner_i2c_regs.sv
module sim_tuner_i2c_regs;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 25;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl = 1'b1;
  logic        sda_m = 1'b1;
  logic [1:0]  addr_sel = 2'b10;
  logic        lock = 1'b1;
  logic [2:0]  cmp = 3'b101;
  logic        sda_oe;
  logic [14:0] div_word;
  logic [6:0]  ctrl_reg;
  logic [4:0]  port_reg;
  wire         sda_line = sda_m & ~sda_oe;

  int n_chk = 0;
  int n_bad = 0;
  int r12_viol = 0;
  logic done = 1'b0;
  logic scl_d = 1'b1, oe_d = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tuner_i2c_regs u0 (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .lock_i(lock), .cmp_i(cmp),
    .div_word(div_word), .ctrl_reg(ctrl_reg), .port_reg(port_reg)
  );

  always @(negedge clk) begin
    if (!rst && scl && scl_d && (sda_oe != oe_d)) r12_viol++;
    scl_d = scl;
    oe_d  = sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq();
    sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); ack = sda_line; wq(); scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl = 1'b1; wq(); d[i] = sda_line; wq(); scl = 1'b0;
    end
    sda_m = mack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq(); sda_m = 1'b1;
  endtask

  task automatic t_reset();
    chk("R9 div_word", div_word, 0);
    chk("R9 ctrl_reg", ctrl_reg, 7'b0000011);
    chk("R9 port_reg", port_reg, 0);
    chk("R9 sda_oe", sda_oe, 0);
  endtask

  task automatic t_read_first();
    logic a; logic [7:0] d;
    bus_start(); send_byte(8'hC5, a);
    chk("R1 read address ack", a, 0);
    recv_byte(1'b0, d);
    chk("R7 R8 first status byte", d, 8'hEF);
    recv_byte(1'b1, d);
    chk("R8 second byte por cleared", d, 8'h6F);
    chk("R10 released after nack", sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_idle_pulses();
    int seen = 0;
    for (int i = 0; i < 9; i++) begin
      wq(); scl = 1'b0; wq(); if (sda_oe) seen++; wq(); scl = 1'b1; wq();
      if (sda_oe) seen++;
    end
    chk("R10 silent on clocks without start", seen, 0);
  endtask

  task automatic t_foreign();
    logic a1, a2, a3, a4;
    bus_start(); send_byte(8'hC0, a1); send_byte(8'h12, a2); send_byte(8'h34, a3); bus_stop();
    chk("R1 foreign address nack", a1, 1);
    chk("R1 foreign data nack", a2 & a3, 1);
    bus_start(); send_byte(8'hC2, a4); send_byte(8'h80, a2); bus_stop();
    chk("R1 swapped select nack", a4, 1);
    chk("R1 foreign write ignored", {div_word, ctrl_reg}, {15'h0, 7'b0000011});
  endtask

  task automatic t_div();
    logic a0, a1, a2;
    bus_start(); send_byte(8'hC4, a0); send_byte(8'h2A, a1);
    chk("R3 divider unchanged after first byte", div_word, 0);
    send_byte(8'h5C, a2); bus_stop();
    chk("R2 data bytes acked", {a0, a1, a2}, 0);
    chk("R3 divider pair", div_word, 15'h2A5C);
  endtask

  task automatic t_ctrl_port();
    logic a;
    bus_start(); send_byte(8'hC4, a); send_byte(8'hA9, a);
    chk("R4 control byte", ctrl_reg, 7'h29);
    chk("R4 port untouched before port byte", port_reg, 0);
    send_byte(8'hD1, a); bus_stop();
    chk("R4 port byte", port_reg, 5'b11011);
    bus_start(); send_byte(8'hC4, a); send_byte(8'hA9, a); send_byte(8'hDE, a); bus_stop();
    chk("R4 port dont-care bits", port_reg, 5'b11010);
  endtask

  task automatic t_multi();
    logic a;
    bus_start(); send_byte(8'hC4, a);
    send_byte(8'h01, a); send_byte(8'h00, a);
    chk("R5 first group", div_word, 15'h0100);
    send_byte(8'h02, a); send_byte(8'h00, a);
    chk("R5 second group", div_word, 15'h0200);
    send_byte(8'h80, a); send_byte(8'h00, a);
    chk("R5 control group", {ctrl_reg, port_reg}, 12'h0);
    send_byte(8'h41, a); send_byte(8'h23, a); bus_stop();
    chk("R5 fourth group", div_word, 15'h4123);
  endtask

  task automatic t_abort();
    logic a;
    bus_start(); send_byte(8'hC4, a); send_byte(8'h7F, a); bus_stop();
    chk("R6 aborted pair keeps divider", div_word, 15'h4123);
    bus_start(); send_byte(8'hC4, a); send_byte(8'h83, a); bus_stop();
    chk("R6 new group after abort", ctrl_reg, 7'h03);
    chk("R6 divider not completed by stale half", div_word, 15'h4123);
  endtask

  task automatic t_rstart();
    logic a; logic [7:0] d;
    bus_start(); send_byte(8'hC4, a); send_byte(8'h05, a);
    bus_start(); send_byte(8'hC4, a);
    chk("R11 address after repeated start", a, 0);
    send_byte(8'h00, a); send_byte(8'h07, a); bus_stop();
    chk("R11 partial discarded", div_word, 15'h0007);
    lock = 1'b0; cmp = 3'b010;
    bus_start(); send_byte(8'hC4, a); send_byte(8'h12, a);
    bus_start(); send_byte(8'hC5, a); recv_byte(1'b1, d); bus_stop();
    chk("R7 status with new inputs", d, 8'h17);
    chk("R11 divider kept", div_word, 15'h0007);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (6) @(negedge clk);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    t_reset();
    t_read_first();
    t_idle_pulses();
    t_foreign();
    t_div();
    t_ctrl_port();
    t_multi();
    t_abort();
    t_rstart();
    chk("R12 no change while SCL high", r12_viol, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule